// File: doc/BRIEF.md
# Single-Bit Time-Slot Engine for a One-Wire Bus Master

This block produces one bit time slot at a time on a one-wire open-drain bus. A "one" slot also serves as a read slot. The block pulls the line low for a short interval and then lets it go. After a data sample offset it captures the line level, and it then idles in the released state until the slot is over. A "zero" slot holds the line low for a long interval, followed by a short recovery interval. Timing runs from a one-microsecond tick that the surrounding logic supplies. Every segment length is counted in ticks.

Three timing sets are available: standard, overdrive and flexible. In flexible mode the initial low time and the sample offset come from two stored settings. A write strobe updates these settings. Each written value is forced into its legal range, and the sample offset is reduced if needed so that low time plus offset never goes above 22 µs. The speed choice and the flexible settings are latched when a slot begins. A caller that sequences bytes pulses `start` once per bit, waits for `done`, and then reads `rd_bit`.

Top module: `bit_slot_engine`

## Requirements
- R1: After synchronous reset, `bus_drive_low`, `done` and `rd_bit` are 0, and the flexible settings are low time 12 and sample offset 7.
- R2: Standard speed (speed_sel 0) in a one/read slot pulls the line low for 8 ticks and samples at tick 14. The slot ends at tick 68.
- R3: Overdrive speed (speed_sel 1) in a one/read slot pulls the line low for 1 tick and samples at tick 2. The slot ends at tick 10.
- R4: Flexible speed (speed_sel 2) in a one/read slot pulls the line low for the stored low time L and samples at tick L+D, where D is the stored offset. The slot ends at tick L+D+54.
- R5: A zero slot pulls the line low for 60 ticks at standard and flexible speed, and for 8 ticks at overdrive. Its total length equals that of a one slot at the same speed. `rd_bit` does not change during a zero slot.
- R6: A flexible-setting write (cfg_wr) forces the low time into 8..15 and the sample offset into 3..10.
- R7: If the forced low time plus the forced offset exceeds 22, the stored offset becomes 22 minus the low time.
- R8: In a read slot, `rd_bit` takes the value `bus_in` has on the tick that ends the sample offset. `done` is a one-cycle pulse in the cycle after the final tick, and `rd_bit` is valid while `done` is high.
- R9: A `start` pulse while a slot is running is ignored and leaves the running slot unchanged.
- R10: Speed, written bit and flexible settings are captured when the slot starts. Changes made during a slot affect only later slots. speed_sel 3 behaves like standard speed.
- R11: Every segment boundary, including the release of the line, happens on a clock edge where `us_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Begin a slot when idle |
| wr_bit | input | 1 | Bit to send; 1 also performs a read |
| speed_sel | input | 2 | 0 standard, 1 overdrive, 2 flexible, 3 standard |
| cfg_wr | input | 1 | Store new flexible settings |
| cfg_low1 | input | 5 | Requested flexible low time in µs |
| cfg_dso | input | 5 | Requested flexible sample offset in µs |
| bus_in | input | 1 | Sensed bus line level |
| bus_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| rd_bit | output | 1 | Level captured in the most recent read slot |
| done | output | 1 | One-cycle pulse at slot end |

## Verification
The bound checker checks on every cycle the rules that hold at any instant. The line is only pulled low inside a slot, and a pull begins only from idle on a start request. The release of the line, each change of the sampled bit and each `done` pulse land one cycle after a tick. `done` never lasts two cycles. Other behaviours can only be shown by the bench's scenarios, because they depend on counting whole slots. These are the exact segment lengths per speed, sampling on precisely the offset-ending tick, the clamping and sum cap of flexible writes, the unchanged read bit across zero slots, and the immunity of a running slot to a second start and to mid-slot setting changes.

// File: rtl/slot_pkg.sv
package slot_pkg;

    localparam int SEG_W = 7;
    localparam int CFG_W = 5;

    localparam int STD_LOW1   = 8;
    localparam int STD_DSO    = 6;
    localparam int STD_HIGH1  = 54;
    localparam int STD_LOW0   = 60;

    localparam int OD_LOW1    = 1;
    localparam int OD_DSO     = 1;
    localparam int OD_HIGH1   = 8;
    localparam int OD_LOW0    = 8;

    localparam int FLEX_HIGH1 = 54;
    localparam int FLEX_LOW0  = 60;
    localparam int FLEX_L_MIN = 8;
    localparam int FLEX_L_MAX = 15;
    localparam int FLEX_D_MIN = 3;
    localparam int FLEX_D_MAX = 10;
    localparam int FLEX_SUM_MAX = 22;
    localparam int FLEX_L_RST = 12;
    localparam int FLEX_D_RST = 7;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_OD   = 2'd1,
        SPD_FLEX = 2'd2,
        SPD_ALT  = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_GAP  = 2'd2,
        ST_TAIL = 2'd3
    } seg_e;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [CFG_W-1:0] cfg_t;

    typedef struct packed {
        seg_t first;
        seg_t second;
        seg_t third;
        logic is_read;
    } slot_plan_t;

    function automatic int limit(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic seg_t fit_low1(input cfg_t v);
        return seg_t'(limit(int'(v), FLEX_L_MIN, FLEX_L_MAX));
    endfunction

    function automatic seg_t fit_dso(input seg_t low1, input cfg_t v);
        int d;
        d = limit(int'(v), FLEX_D_MIN, FLEX_D_MAX);
        if (int'(low1) + d > FLEX_SUM_MAX) d = FLEX_SUM_MAX - int'(low1);
        return seg_t'(d);
    endfunction

    function automatic slot_plan_t make_plan(input speed_e spd, input logic wbit,
                                             input seg_t low1, input seg_t dso);
        slot_plan_t p;
        int l, d, h, l0;
        case (spd)
            SPD_OD: begin
                l = OD_LOW1; d = OD_DSO; h = OD_HIGH1; l0 = OD_LOW0;
            end
            SPD_FLEX: begin
                l = int'(low1); d = int'(dso); h = FLEX_HIGH1; l0 = FLEX_LOW0;
            end
            default: begin
                l = STD_LOW1; d = STD_DSO; h = STD_HIGH1; l0 = STD_LOW0;
            end
        endcase
        if (wbit) begin
            p.first   = seg_t'(l);
            p.second  = seg_t'(d);
            p.third   = seg_t'(h);
            p.is_read = 1'b1;
        end else begin
            p.first   = seg_t'(l0);
            p.second  = seg_t'(l + d + h - l0);
            p.third   = seg_t'(1);
            p.is_read = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/flex_timing_reg.sv
module flex_timing_reg
    import slot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cfg_t low1_in,
    input  cfg_t dso_in,
    output seg_t low1_q,
    output seg_t dso_q
);
    seg_t low1_fit;
    seg_t dso_fit;

    always_comb begin
        low1_fit = fit_low1(low1_in);
        dso_fit  = fit_dso(low1_fit, dso_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low1_q <= seg_t'(FLEX_L_RST);
            dso_q  <= seg_t'(FLEX_D_RST);
        end else if (wr_en) begin
            low1_q <= low1_fit;
            dso_q  <= dso_fit;
        end
    end
endmodule

// File: rtl/slot_planner.sv
module slot_planner
    import slot_pkg::*;
(
    input  speed_e     spd,
    input  logic       wbit,
    input  seg_t       low1,
    input  seg_t       dso,
    output slot_plan_t plan
);
    always_comb plan = make_plan(spd, wbit, low1, dso);
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  slot_plan_t plan,
    input  logic       bus_in,
    output logic       pull_low,
    output logic       active,
    output logic       rd_bit,
    output logic       done
);
    seg_e       state;
    seg_t       cnt;
    slot_plan_t plan_q;
    logic       last;

    assign last     = (cnt == seg_t'(1));
    assign pull_low = (state == ST_LOW);
    assign active   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            plan_q <= '0;
            rd_bit <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        plan_q <= plan;
                        cnt    <= plan.first;
                        state  <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        if (last) begin
                            cnt   <= plan_q.second;
                            state <= ST_GAP;
                        end else begin
                            cnt <= cnt - seg_t'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (last) begin
                            if (plan_q.is_read) begin
                                rd_bit <= bus_in;
                                cnt    <= plan_q.third;
                                state  <= ST_TAIL;
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt - seg_t'(1);
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt - seg_t'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bit_slot_engine.sv
module bit_slot_engine
    import slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             us_tick,
    input  logic             start,
    input  logic             wr_bit,
    input  logic [1:0]       speed_sel,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_low1,
    input  logic [CFG_W-1:0] cfg_dso,
    input  logic             bus_in,
    output logic             bus_drive_low,
    output logic             rd_bit,
    output logic             done
);
    seg_t       flex_low1;
    seg_t       flex_dso;
    slot_plan_t next_plan;
    logic       slot_active;

    flex_timing_reg u_flex (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .low1_in (cfg_low1),
        .dso_in  (cfg_dso),
        .low1_q  (flex_low1),
        .dso_q   (flex_dso)
    );

    slot_planner u_plan (
        .spd  (speed_e'(speed_sel)),
        .wbit (wr_bit),
        .low1 (flex_low1),
        .dso  (flex_dso),
        .plan (next_plan)
    );

    slot_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (us_tick),
        .start    (start),
        .plan     (next_plan),
        .bus_in   (bus_in),
        .pull_low (bus_drive_low),
        .active   (slot_active),
        .rd_bit   (rd_bit),
        .done     (done)
    );
endmodule

// File: rtl/slot_checks.sv
module slot_checks (
    input logic clk,
    input logic rst,
    input logic us_tick,
    input logic start,
    input logic bus_drive_low,
    input logic done,
    input logic rd_bit,
    input logic slot_active
);
    // R1: line pulled low only while a slot runs
    a_r1_drive_in_slot: assert property (@(posedge clk) disable iff (rst)
        bus_drive_low |-> slot_active);

    // R9: a pull begins only from idle with a start request
    a_r9_pull_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drive_low) |-> ($past(start) && !$past(slot_active)));

    // R11: release of the line follows a tick
    a_r11_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_drive_low) |-> $past(us_tick));

    // R8: done follows a tick and lasts one cycle
    a_r8_done_on_tick: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(us_tick));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: sampled bit changes only on a tick inside a slot
    a_r8_sample_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_bit) |-> ($past(us_tick) && $past(slot_active)));
endmodule

bind bit_slot_engine slot_checks u_slot_checks (
    .clk           (clk),
    .rst           (rst),
    .us_tick       (us_tick),
    .start         (start),
    .bus_drive_low (bus_drive_low),
    .done          (done),
    .rd_bit        (rd_bit),
    .slot_active   (slot_active)
);

// File: tb/test_bit_slot_engine.sv
module test_bit_slot_engine;
    localparam int TICK_DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic       wr_bit = 1'b0;
    logic [1:0] speed_sel = 2'd0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_low1 = '0;
    logic [4:0] cfg_dso = '0;
    logic       bus_in;
    logic       bus_drive_low;
    logic       rd_bit;
    logic       done;

    typedef struct {
        int    low_len;
        int    total;
        int    rd_exp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_done = 0;
    int   cnt = 0;
    int   low_seen = 0;
    int   div = 0;
    int   cur_sample = 0;
    bit   cur_resp = 1'b0;
    bit   in_slot = 1'b0;
    bit   prev_low = 1'b0;
    bit   prev_done = 1'b0;
    bit   last_rd = 1'b0;
    int   m_low1 = 12;
    int   m_dso = 7;

    always #10 clk = ~clk;

    assign bus_in = bus_drive_low ? 1'b0 :
                    ((in_slot && us_tick && cnt == cur_sample) ? cur_resp : ~cur_resp);

    bit_slot_engine i_bit_slot_engine (
        .clk           (clk),
        .rst           (rst),
        .us_tick       (us_tick),
        .start         (start),
        .wr_bit        (wr_bit),
        .speed_sel     (speed_sel),
        .cfg_wr        (cfg_wr),
        .cfg_low1      (cfg_low1),
        .cfg_dso       (cfg_dso),
        .bus_in        (bus_in),
        .bus_drive_low (bus_drive_low),
        .rd_bit        (rd_bit),
        .done          (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor, tick source and scoreboard, all on the falling edge
    always @(negedge clk) begin
        if (done) begin
            check(!prev_done, "R8 done width", 1, 0);
            if (q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(low_seen == e.low_len, {e.tag, " low length"}, low_seen, e.low_len);
                check(cnt == e.total, {e.tag, " slot length"}, cnt, e.total);
                check(int'(rd_bit) == e.rd_exp, {e.tag, " read bit"}, int'(rd_bit), e.rd_exp);
                check(!bus_drive_low, {e.tag, " released at end"}, int'(bus_drive_low), 0);
            end
            in_slot = 1'b0;
            n_done++;
        end
        if (bus_drive_low && !prev_low && !in_slot) begin
            in_slot  = 1'b1;
            cnt      = 0;
            low_seen = 0;
        end
        div = (div == TICK_DIV - 1) ? 0 : div + 1;
        us_tick = (div == 0);
        if (in_slot && us_tick) begin
            cnt++;
            if (bus_drive_low) low_seen = cnt;
        end
        prev_low  = bus_drive_low;
        prev_done = done;
    end

    task automatic write_cfg(input int l, input int d);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_low1 = 5'(l);
        cfg_dso  = 5'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_low1 = (l < 8) ? 8 : (l > 15) ? 15 : l;
        m_dso  = (d < 3) ? 3 : (d > 10) ? 10 : d;
        if (m_low1 + m_dso > 22) m_dso = 22 - m_low1;
    endtask

    task automatic run_slot(input bit b, input int spd, input bit resp,
                            input string tag, input bit poke);
        exp_t e;
        int   l, d, h, k;
        if (spd == 1) begin
            l = 1; d = 1; h = 8;
        end else if (spd == 2) begin
            l = m_low1; d = m_dso; h = 54;
        end else begin
            l = 8; d = 6; h = 54;
        end
        e.total = l + d + h;
        e.tag   = tag;
        if (b) begin
            e.low_len  = l;
            e.rd_exp   = int'(resp);
            cur_sample = l + d;
            cur_resp   = resp;
        end else begin
            e.low_len  = (spd == 1) ? 8 : 60;
            e.rd_exp   = int'(last_rd);
            cur_sample = 0;
            cur_resp   = last_rd;
        end
        last_rd = e.rd_exp[0];
        q.push_back(e);
        k = n_done;
        @(negedge clk);
        wr_bit    = b;
        speed_sel = 2'(spd);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            wr_bit    = ~b;
            speed_sel = 2'd1;
            start     = 1'b1;
            cfg_wr    = 1'b1;
            cfg_low1  = 5'd15;
            cfg_dso   = 5'd3;
            @(negedge clk);
            start  = 1'b0;
            cfg_wr = 1'b0;
            m_low1 = 15;
            m_dso  = 3;
        end
        wait (n_done > k);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!bus_drive_low, "R1 drive", int'(bus_drive_low), 0);
        check(!done, "R1 done", int'(done), 0);
        check(!rd_bit, "R1 rd_bit", int'(rd_bit), 0);

        run_slot(1'b1, 0, 1'b1, "R2 std read 1", 1'b0);
        run_slot(1'b1, 0, 1'b0, "R2 std read 0", 1'b0);
        run_slot(1'b1, 1, 1'b1, "R3 od read 1", 1'b0);
        run_slot(1'b1, 1, 1'b0, "R3 od read 0", 1'b0);
        run_slot(1'b1, 2, 1'b1, "R4 flex default", 1'b0);
        run_slot(1'b0, 0, 1'b0, "R5 std zero", 1'b0);
        run_slot(1'b0, 1, 1'b0, "R5 od zero", 1'b0);
        run_slot(1'b0, 2, 1'b0, "R5 flex zero", 1'b0);

        write_cfg(2, 1);
        run_slot(1'b1, 2, 1'b0, "R6 clamp low", 1'b0);
        write_cfg(0, 31);
        run_slot(1'b1, 2, 1'b1, "R6 clamp mixed", 1'b0);

        write_cfg(20, 20);
        run_slot(1'b1, 2, 1'b0, "R7 cap at max", 1'b0);
        write_cfg(14, 10);
        run_slot(1'b1, 2, 1'b1, "R7 cap reduces offset", 1'b0);
        write_cfg(9, 10);
        run_slot(1'b1, 2, 1'b0, "R7 under cap kept", 1'b0);
        run_slot(1'b0, 2, 1'b0, "R5 flex zero after write", 1'b0);

        run_slot(1'b1, 0, 1'b1, "R9 R10 restart ignored", 1'b1);
        run_slot(1'b1, 2, 1'b0, "R10 new settings next slot", 1'b0);
        run_slot(1'b1, 3, 1'b1, "R10 code 3 as std", 1'b0);
        run_slot(1'b0, 3, 1'b1, "R11 zero slot code 3", 1'b0);

        check(q.size() == 0, "R9 pending items", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule